// File: doc/BRIEF.md
# Single-Channel Bus-Mastering Block Mover

This engine moves a run of words between one peripheral and system memory without the processor touching each word. Software first loads a start address, a word count, a per-ownership block size and a transfer style. It then sets the go bit. The engine stays armed until the peripheral reports that it is ready. At that point the engine raises a bus request. Once the processor acknowledges, the engine runs up to one block of bus accesses, with each access held until the memory answers ready. It then lets go of the bus.

Between blocks the engine gives the bus back to the processor. It waits for acknowledge to fall and for the peripheral to be ready again before it asks for the bus once more. Once the last word has moved and the bus has been returned, it raises a one-cycle interrupt and sets a sticky done flag. Direction can be peripheral-to-memory or memory-to-peripheral. The memory address either steps by one word per access or stays fixed, which suits a FIFO-style memory port.

Top module: `busmaster_dma`

## Requirements
- R1: The setup registers are selected by `cfg_sel`: 0 holds the start address, 1 the total word count, 2 the block size and 3 the control word. Control bit 0 is go, bit 1 set means memory-to-peripheral (clear means peripheral-to-memory), and bit 2 set holds the address fixed. After go, no request is made until `per_avail` is high. Register writes made while a transfer is in progress are ignored.
- R2: `bus_valid` is never high unless both `bus_req` and `bus_ack` are high. The request rises in the cycle after the armed engine sees `per_avail`.
- R3: Each completed access advances the address by one word from the start address. In fixed mode every access uses the start address.
- R4: In peripheral-to-memory mode `bus_we` is 1, `bus_wdata` carries `per_rd_data`, and `per_pop` pulses once per completed access. In memory-to-peripheral mode `bus_we` is 0, and `per_push` pulses with `per_wr_data` equal to `bus_rdata`.
- R5: An access completes only on a cycle with `bus_ready` high. While ready is low, `bus_valid` stays high and `bus_addr` does not change.
- R6: One bus ownership carries at most the block size in accesses. After the final access of a block there is one cycle with the request still high and `bus_valid` low, and then the request drops.
- R7: The last block is shortened to the words that remain. A block size of 0 acts as 1.
- R8: When the whole count has moved and acknowledge has fallen, `irq` is high for exactly one cycle. `done` then stays high until the next go.
- R9: A go with a word count of 0 produces the `irq` pulse and sets `done` without ever raising `bus_req`.
- R10: Reset leaves `bus_req`, `bus_valid`, `irq` and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Setup register write strobe |
| cfg_sel | input | 2 | Setup register select |
| cfg_wdata | input | AW | Setup register write data |
| per_avail | input | 1 | Peripheral ready to give or take a word |
| per_rd_data | input | DW | Word offered by the peripheral |
| per_pop | output | 1 | Peripheral word consumed |
| per_wr_data | output | DW | Word delivered to the peripheral |
| per_push | output | 1 | Word delivered strobe |
| bus_req | output | 1 | Bus ownership request to the processor |
| bus_ack | input | 1 | Bus ownership granted |
| bus_valid | output | 1 | Access in progress |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | AW | Access word address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data |
| bus_ready | input | 1 | Memory completes the access |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle completion pulse |

## Verification
Two events can land on the same clock edge. In one, the access that fills a block is also the access that uses up the word count, so the block close and the transfer close share a cycle. The bench provokes this with counts that are not multiples of the block size and with a block size of 0. It judges the outcome by counting request rises and `irq` pulses: there must be exactly one of each per expected block and per transfer, and no stray request may follow the last block. In the other, go with a zero count collides with completion in the very next cycle. This case is judged by an `irq` pulse that arrives with no request ever seen.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_REQ,
    ST_MOVE,
    ST_DROP,
    ST_HANDBACK,
    ST_FINISH
  } bm_state_e;

  typedef struct packed {
    logic hold_addr;
    logic mem_to_per;
  } bm_style_t;

  localparam int unsigned CTRL_GO   = 0;
  localparam int unsigned CTRL_DIR  = 1;
  localparam int unsigned CTRL_HOLD = 2;

  // words carried in the next bus ownership
  function automatic logic [31:0] bm_burst_words(input logic [31:0] blk,
                                                 input logic [31:0] rem);
    logic [31:0] eff;
    eff = (blk == 32'd0) ? 32'd1 : blk;
    return (eff < rem) ? eff : rem;
  endfunction

  // address used by the access after a completed one
  function automatic logic [31:0] bm_step_addr(input logic [31:0] addr,
                                               input logic hold);
    return hold ? addr : addr + 32'd1;
  endfunction

endpackage

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          busy,
  output logic [AW-1:0] start_addr,
  output logic [LW-1:0] total_len,
  output logic [LW-1:0] blk_len,
  output bm_style_t     style,
  output logic          go
);

  logic wr_ok;
  assign wr_ok = cfg_we && !busy;
  assign go    = wr_ok && (cfg_sel == 2'd3) && cfg_wdata[CTRL_GO];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_addr <= '0;
      total_len  <= '0;
      blk_len    <= '0;
      style      <= '0;
    end else if (wr_ok) begin
      case (cfg_sel)
        2'd0:    start_addr <= cfg_wdata;
        2'd1:    total_len  <= cfg_wdata[LW-1:0];
        2'd2:    blk_len    <= cfg_wdata[LW-1:0];
        default: begin
          style.mem_to_per <= cfg_wdata[CTRL_DIR];
          style.hold_addr  <= cfg_wdata[CTRL_HOLD];
        end
      endcase
    end
  end

  // R1: setup is frozen while a transfer runs
  p_cfg_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(style) && $stable(start_addr) && $stable(total_len)));

endmodule

// File: rtl/bmdma_datapath.sv
module bmdma_datapath
  import bmdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] total_len,
  input  logic [LW-1:0] blk_len,
  input  logic          hold_addr,
  input  logic          blk_load,
  input  logic          beat,
  output logic [AW-1:0] cur_addr,
  output logic          remain_zero,
  output logic          blk_last
);

  logic [AW-1:0] addr_q;
  logic [LW-1:0] remain_q;
  logic [LW-1:0] blk_left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q     <= '0;
      remain_q   <= '0;
      blk_left_q <= '0;
    end else begin
      if (load) begin
        addr_q   <= start_addr;
        remain_q <= total_len;
      end else if (beat) begin
        addr_q   <= AW'(bm_step_addr(32'(addr_q), hold_addr));
        remain_q <= remain_q - LW'(1);
      end
      if (blk_load)
        blk_left_q <= LW'(bm_burst_words(32'(blk_len), 32'(remain_q)));
      else if (beat)
        blk_left_q <= blk_left_q - LW'(1);
    end
  end

  assign cur_addr    = addr_q;
  assign remain_zero = (remain_q == '0);
  assign blk_last    = (blk_left_q == LW'(1));

  // R6/R7: no access beyond the block or the remaining count
  p_beat_in_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> (blk_left_q != '0) && (remain_q != '0));

  // R3: fixed mode keeps the address after an access
  p_hold_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && hold_addr) |=> (addr_q == $past(addr_q)));

endmodule

// File: rtl/bmdma_ctrl.sv
module bmdma_ctrl
  import bmdma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic len_zero,
  input  logic per_avail,
  input  logic bus_ack,
  input  logic bus_ready,
  input  logic blk_last,
  input  logic remain_zero,
  output logic bus_req,
  output logic bus_valid,
  output logic blk_load,
  output logic beat,
  output logic irq,
  output logic done,
  output logic busy
);

  bm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (go) state_d = len_zero ? ST_FINISH : ST_ARMED;
      ST_ARMED:    if (per_avail) state_d = ST_REQ;
      ST_REQ:      if (bus_ack) state_d = ST_MOVE;
      ST_MOVE:     if (bus_ready && blk_last) state_d = ST_DROP;
      ST_DROP:     state_d = ST_HANDBACK;
      ST_HANDBACK: if (!bus_ack) state_d = remain_zero ? ST_FINISH : ST_ARMED;
      ST_FINISH:   state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (go) done <= 1'b0;
      else if (state_q == ST_FINISH) done <= 1'b1;
    end
  end

  assign bus_req   = (state_q == ST_REQ) || (state_q == ST_MOVE) || (state_q == ST_DROP);
  assign bus_valid = (state_q == ST_MOVE);
  assign beat      = bus_valid && bus_ready;
  assign blk_load  = (state_q == ST_ARMED) && per_avail;
  assign irq       = (state_q == ST_FINISH);
  assign busy      = (state_q != ST_IDLE);

  // R2: the bus is driven only while owned
  p_own_before_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_req && bus_ack));

  // R6: request falls only after a cycle with the bus idle
  p_release_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> !$past(bus_valid));

  // R8: completion pulse lasts one cycle and leaves done set
  p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> (!irq && done));

  // R9: zero count completes at once without a request
  p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (go && len_zero) |=> (irq && !bus_req));

endmodule

// File: rtl/busmaster_dma.sv
module busmaster_dma
  import bmdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          per_avail,
  input  logic [DW-1:0] per_rd_data,
  output logic          per_pop,
  output logic [DW-1:0] per_wr_data,
  output logic          per_push,
  output logic          bus_req,
  input  logic          bus_ack,
  output logic          bus_valid,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready,
  output logic          done,
  output logic          irq
);

  localparam int CTRL_BITS = 3;

  logic [AW-1:0] start_addr, cur_addr;
  logic [LW-1:0] total_len, blk_len;
  bm_style_t     style;
  logic          go, busy, blk_load, beat, remain_zero, blk_last, len_zero;
  logic          to_mem;

  bmdma_regs #(.AW(AW), .LW(LW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .start_addr(start_addr),
    .total_len(total_len), .blk_len(blk_len), .style(style), .go(go)
  );

  bmdma_datapath #(.AW(AW), .LW(LW)) u_path (
    .clk(clk), .rst_n(rst_n), .load(go), .start_addr(start_addr),
    .total_len(total_len), .blk_len(blk_len), .hold_addr(style.hold_addr),
    .blk_load(blk_load), .beat(beat), .cur_addr(cur_addr),
    .remain_zero(remain_zero), .blk_last(blk_last)
  );

  assign len_zero = (total_len == '0);

  bmdma_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .go(go), .len_zero(len_zero),
    .per_avail(per_avail), .bus_ack(bus_ack), .bus_ready(bus_ready),
    .blk_last(blk_last), .remain_zero(remain_zero), .bus_req(bus_req),
    .bus_valid(bus_valid), .blk_load(blk_load), .beat(beat), .irq(irq),
    .done(done), .busy(busy)
  );

  assign to_mem      = !style.mem_to_per;
  assign bus_addr    = bus_valid ? cur_addr : '0;
  assign bus_we      = bus_valid && to_mem;
  assign bus_wdata   = (bus_valid && to_mem) ? per_rd_data : '0;
  assign per_pop     = beat && to_mem;
  assign per_push    = beat && !to_mem;
  assign per_wr_data = bus_rdata;

  // R5: a stalled access holds address and valid
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr)));

  // R4: only one peripheral strobe at a time
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({per_pop, per_push}));

  initial begin
    p_widths_r1: assert (AW >= LW && AW >= CTRL_BITS && AW <= 32);
  end

endmodule

// File: tb/busmaster_dma_bench.sv
module busmaster_dma_bench;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int LW = 12;
  localparam int NV = 6;

  // start, count, block, mem_to_per, hold, memory delay, ack delay
  localparam int VSTART [NV] = '{16, 32, 64, 96, 128, 160};
  localparam int VLEN   [NV] = '{8, 7, 5, 6, 4, 3};
  localparam int VBLK   [NV] = '{4, 3, 8, 2, 4, 0};
  localparam int VM2P   [NV] = '{0, 0, 1, 1, 0, 0};
  localparam int VHOLD  [NV] = '{0, 0, 0, 1, 1, 0};
  localparam int VMDLY  [NV] = '{0, 2, 1, 0, 3, 0};
  localparam int VADLY  [NV] = '{0, 1, 0, 2, 0, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic per_avail = 1'b0;
  logic [DW-1:0] src_val = 16'h5000;
  logic per_pop, per_push, bus_req, bus_valid, bus_we, done, irq;
  logic [DW-1:0] per_wr_data, bus_wdata;
  logic [AW-1:0] bus_addr;
  logic bus_ack = 1'b0;
  logic bus_ready = 1'b0;
  logic [DW-1:0] bus_rdata = '0;

  always #10 clk = ~clk;

  busmaster_dma #(.AW(AW), .DW(DW), .LW(LW)) u_busmaster_dma (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .per_avail(per_avail), .per_rd_data(src_val),
    .per_pop(per_pop), .per_wr_data(per_wr_data), .per_push(per_push),
    .bus_req(bus_req), .bus_ack(bus_ack), .bus_valid(bus_valid),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .done(done), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] mem [256];
  logic [DW-1:0] sink [128];
  int sink_n = 0;
  int mdly = 0, adly = 0, m_cnt = 0, a_cnt = 0;
  int beats = 0, blocks = 0, irq_cnt = 0;
  int addr_err = 0, stall_err = 0, drive_err = 0, we_err = 0;
  int cur_start = 0, cur_hold = 0, cur_m2p = 0;
  logic prev_req = 1'b0, prev_valid = 1'b0, prev_stall = 1'b0;
  logic [AW-1:0] prev_addr = '0;

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 3 + 256);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // peripheral source and sink
  always @(posedge clk) begin
    if (per_pop) src_val <= src_val + 16'd1;
    if (per_push && sink_n < 128) begin
      sink[sink_n] <= per_wr_data;
      sink_n <= sink_n + 1;
    end
  end

  // processor ack model, memory model and bus monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) irq_cnt++;
      if (bus_req && !prev_req) blocks++;
      if (bus_valid && !(bus_ack && bus_req)) drive_err++;
      if (prev_req && !bus_req && prev_valid) drive_err++;
      if (bus_valid && prev_stall && bus_addr != prev_addr) stall_err++;
      if (bus_valid && (bus_we != (cur_m2p == 0))) we_err++;
      if (bus_ready) begin
        bus_ready = 1'b0;
        m_cnt = 0;
      end else if (bus_valid) begin
        if (m_cnt >= mdly) begin
          if (int'(bus_addr) != (cur_hold != 0 ? cur_start : cur_start + beats)) addr_err++;
          if (bus_we) mem[bus_addr[7:0]] = bus_wdata;
          else bus_rdata = mem[bus_addr[7:0]];
          beats++;
          bus_ready = 1'b1;
        end else m_cnt++;
      end
      prev_stall = bus_valid && !bus_ready;
      prev_addr = bus_addr;
      if (!bus_req) begin
        bus_ack = 1'b0;
        a_cnt = 0;
      end else if (!bus_ack) begin
        if (a_cnt >= adly) bus_ack = 1'b1;
        else a_cnt++;
      end
      prev_req = bus_req;
      prev_valid = bus_valid;
    end
  end

  task automatic cfg_write(input int sel, input int data);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_sel = 2'(sel);
    cfg_wdata = AW'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_counts();
    @(negedge clk);
    beats = 0; blocks = 0; irq_cnt = 0;
    addr_err = 0; stall_err = 0; drive_err = 0; we_err = 0;
  endtask

  task automatic wait_irq();
    for (int t = 0; t < 3000 && irq_cnt == 0; t++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    repeat (4) @(negedge clk);
    // R10: reset state
    check(!bus_req && !bus_valid, "R10 bus idle in reset", int'(bus_req), 0);
    check(!irq && !done, "R10 irq/done low in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    per_avail = 1'b1;
    for (int v = 0; v < NV; v++) begin
      int src0, snk0, bad, eb, b;
      bit wrote_mid;
      clear_counts();
      mdly = VMDLY[v]; adly = VADLY[v];
      cur_start = VSTART[v]; cur_hold = VHOLD[v]; cur_m2p = VM2P[v];
      src0 = int'(src_val); snk0 = sink_n;
      cfg_write(0, VSTART[v]);
      cfg_write(1, VLEN[v]);
      cfg_write(2, VBLK[v]);
      cfg_write(3, (VHOLD[v] << 2) | (VM2P[v] << 1) | 1);
      check(done == 1'b0, "R8 done cleared by go", int'(done), 0);
      wrote_mid = 1'b0;
      for (int t = 0; t < 3000 && irq_cnt == 0; t++) begin
        // R1: a mid-transfer control write must be ignored
        if (v == 1 && blocks == 1 && !wrote_mid) begin
          wrote_mid = 1'b1;
          cfg_write(3, 6);
        end else @(negedge clk);
      end
      repeat (3) @(negedge clk);
      b = (VBLK[v] == 0) ? 1 : VBLK[v];
      eb = (VLEN[v] + b - 1) / b;
      check(irq_cnt == 1, "R8 single irq", irq_cnt, 1);
      check(done == 1'b1, "R8 done held", int'(done), 1);
      check(blocks == eb, "R6 R7 ownership count", blocks, eb);
      check(beats == VLEN[v], "R3 access count", beats, VLEN[v]);
      check(addr_err == 0, "R3 access addresses", addr_err, 0);
      check(drive_err == 0, "R2 R6 ownership order", drive_err, 0);
      check(stall_err == 0, "R5 stall stability", stall_err, 0);
      check(we_err == 0, "R1 R4 direction kept", we_err, 0);
      bad = 0;
      if (VM2P[v] == 0) begin
        if (VHOLD[v] != 0) begin
          if (mem[VSTART[v]] !== DW'(src0 + VLEN[v] - 1)) bad++;
          if (mem[VSTART[v] + 1] !== pat(VSTART[v] + 1)) bad++;
        end else
          for (int k = 0; k < VLEN[v]; k++)
            if (mem[VSTART[v] + k] !== DW'(src0 + k)) bad++;
        check(int'(src_val) - src0 == VLEN[v], "R4 pops counted", int'(src_val) - src0, VLEN[v]);
      end else begin
        for (int k = 0; k < VLEN[v]; k++)
          if (sink[snk0 + k] !== pat(VHOLD[v] != 0 ? VSTART[v] : VSTART[v] + k)) bad++;
        check(sink_n - snk0 == VLEN[v], "R4 pushes counted", sink_n - snk0, VLEN[v]);
      end
      check(bad == 0, "R4 data moved", bad, 0);
    end

    // R9: zero count
    clear_counts();
    cfg_write(1, 0);
    cfg_write(3, 1);
    repeat (5) @(negedge clk);
    check(irq_cnt == 1, "R9 zero count irq", irq_cnt, 1);
    check(blocks == 0, "R9 no request", blocks, 0);
    check(done == 1'b1, "R9 done set", int'(done), 1);

    // R1: armed engine waits for the peripheral
    clear_counts();
    per_avail = 1'b0;
    mdly = 0; adly = 0; cur_start = 200; cur_hold = 0; cur_m2p = 0;
    cfg_write(0, 200);
    cfg_write(1, 2);
    cfg_write(2, 2);
    cfg_write(3, 1);
    repeat (10) @(negedge clk);
    check(blocks == 0 && !bus_req, "R1 no request before avail", blocks, 0);
    begin
      int s0;
      s0 = int'(src_val);
      per_avail = 1'b1;
      wait_irq();
      check(mem[200] === DW'(s0) && mem[201] === DW'(s0 + 1), "R1 R4 move after avail",
            int'(mem[201]), s0 + 1);
      check(blocks == 1, "R2 one ownership", blocks, 1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule